// File: doc/BRIEF.md
# Reset-Time Boot Image Loader

This block places a fixed 128-byte start-up program into the lowest 128 bytes of a coprocessor's 32-bit RAM each time the coprocessor is put into reset. The program is held in four byte-wide read-only tables of 32 entries. Each table feeds one byte lane, so table n, entry k lands at RAM byte address 4*k+n. The tables are built into the block as computed constants.

A host drives a reset-request level. Each rising edge of that level starts a copy of 32 full-word writes on consecutive clocks, with all byte enables set. The block drives the coprocessor's reset (`cpu_hold`) itself. That reset stays asserted while the request is high, while a copy is running, and from block reset until the first complete copy. A host that drops its request in the middle of a copy cannot release the coprocessor onto a half-written program.

Top module: `boot_image_loader`

## Requirements
- R1: While `rst_n` is low and in the cycles after it, before any request edge, `busy` and `ram_we` are 0 and `cpu_hold` is 1.
- R2: A rising edge of `rst_req` seen at a clock edge sets `busy` from that edge on for exactly 32 cycles. During those cycles `ram_we` is 1 and `ram_be` is 4'hF. Outside them `ram_we` is 0.
- R3: The words are written in order k = 0..31, one per busy cycle, at byte address `ram_addr` = 4*k.
- R4: Byte lane n (bits 8n+7:8n) of word k carries (29*k + 71*n + 60) mod 256.
- R5: `cpu_hold` is 1 in every cycle in which `rst_req` or `busy` is 1.
- R6: If `rst_req` falls during a copy, `cpu_hold` stays 1 until the copy ends. It drops in the first cycle with `busy` low.
- R7: After block reset, `cpu_hold` stays 1 while `rst_req` is low until a complete copy has been written.
- R8: A new rising edge of `rst_req` after a finished copy writes the whole image again from word 0.
- R9: A rising edge of `rst_req` during a copy restarts it at word 0, and 32 busy cycles follow from that edge.
- R10: Holding `rst_req` high does not start further copies. `busy` stays 0 and `cpu_hold` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req | input | 1 | Host request to hold the coprocessor in reset; rising edge starts a copy |
| ram_we | output | 1 | RAM write strobe, one word per cycle |
| ram_be | output | 4 | RAM byte enables |
| ram_addr | output | 7 | RAM byte address of the word being written |
| ram_wdata | output | 32 | RAM write data, lane n from table n |
| busy | output | 1 | Copy in progress |
| cpu_hold | output | 1 | Reset to the coprocessor |

## Verification
Two functions can land in the same cycle, and the bench drives both collisions. First, the host can withdraw its request in the middle of a copy. The bench drops `rst_req` at word 10. It then checks that `cpu_hold` stays high through the last write and falls exactly in the cycle `busy` clears. Second, a new request edge can arrive while the sequencer is advancing. The bench pulses `rst_req` low and high at word 5 and expects word 6 and then word 0 on consecutive cycles. After that it expects a full 32-word run with correct data.

// File: rtl/boot_image_pkg.sv
// Shared constants and the computed boot image contents.
// Assumes byte-wide lanes. The image is a pure function of lane and entry.
package boot_image_pkg;
    localparam int BYTE_W = 8;

    // Content of table `lane`, entry `k`
    function automatic logic [BYTE_W-1:0] image_byte(input int lane, input int k);
        int v;
        v = (k * 29 + lane * 71 + 60) % 256;
        return BYTE_W'(v);
    endfunction
endpackage

// File: rtl/boot_image_table.sv
// One read-only byte table feeding a single byte lane.
// Assumes idx < DEPTH. Contents are computed from the package function.
module boot_image_table
    import boot_image_pkg::*;
#(
    parameter int LANE  = 0,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] data
);
    logic [BYTE_W-1:0] rom [DEPTH];

    // Build the constant table
    always_comb begin
        for (int k = 0; k < DEPTH; k++) rom[k] = image_byte(LANE, k);
    end

    // Look up the current entry
    assign data = rom[idx];
endmodule

// File: rtl/boot_copy_seq.sv
// Copy sequencer: detects request rising edges and walks the word index.
// Assumes a synchronous active-low reset. A new edge always restarts at 0.
module boot_copy_seq #(
    parameter int WORDS = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last_wr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    logic req_q;
    logic start;

    assign start = rst_req & ~req_q;

    // Final word written this cycle, and no restart pending at this edge
    assign last_wr = busy & (idx == LAST) & ~start;

    // Edge history, busy flag and word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            busy  <= 1'b0;
            idx   <= '0;
        end else begin
            req_q <= rst_req;
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                if (idx == LAST) busy <= 1'b0;
                else             idx  <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/boot_hold_ctrl.sv
// Coprocessor reset control: keeps the reset asserted until a complete
// image is present and the host has let go of its request.
module boot_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic busy,
    input  logic last_wr,
    output logic cpu_hold
);
    logic img_ok;

    // Remember that one full copy has completed since block reset
    always_ff @(posedge clk) begin
        if (!rst_n)       img_ok <= 1'b0;
        else if (last_wr) img_ok <= 1'b1;
    end

    // Release only when idle, not requested and the image is whole
    assign cpu_hold = rst_req | busy | ~img_ok;
endmodule

// File: rtl/boot_image_loader.sv
// Top: copies the boot image into coprocessor RAM on every reset request.
// Assumes LANES is a power of two and the RAM accepts one word per clock.
module boot_image_loader
    import boot_image_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int LANES = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = IDX_W + $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    output logic              ram_we,
    output logic [LANES-1:0]  ram_be,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              cpu_hold
);
    logic [IDX_W-1:0] idx;
    logic             last_wr;

    boot_copy_seq #(.WORDS(WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .busy(busy), .idx(idx), .last_wr(last_wr)
    );

    boot_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .busy(busy), .last_wr(last_wr), .cpu_hold(cpu_hold)
    );

    // One table per byte lane, interleaved into the word
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        boot_image_table #(.LANE(n), .DEPTH(WORDS)) u_tab (
            .idx(idx), .data(ram_wdata[n*BYTE_W +: BYTE_W])
        );
    end

    // Write port: full words while copying
    assign ram_we   = busy;
    assign ram_be   = {LANES{busy}};
    assign ram_addr = {idx, {($clog2(LANES)){1'b0}}};
endmodule

// File: rtl/boot_image_loader_chk.sv
// Protocol checks for boot_image_loader, attached by bind.
module boot_image_loader_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              busy,
    input logic              cpu_hold
);
    // R2: a request edge starts a copy on the next cycle
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !$past(rst_req)) |=> busy);

    // R3: a fresh copy begins at address 0
    p_first_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ram_addr == '0);

    // R3: consecutive busy cycles step one word unless restarted
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !($past(rst_req) && !$past(rst_req, 2)))
        |-> ram_addr == ADDR_W'($past(ram_addr) + LANES));

    // R5: coprocessor held whenever requested or copying
    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || busy) |-> cpu_hold);

    // R6: copy end with request gone releases the coprocessor
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !rst_req) |-> !cpu_hold);
endmodule

bind boot_image_loader boot_image_loader_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .ram_addr(ram_addr), .busy(busy), .cpu_hold(cpu_hold)
);

// File: tb/boot_image_loader_tb.sv
module boot_image_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        ram_we;
    logic [3:0]  ram_be;
    logic [6:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic        busy;
    logic        cpu_hold;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    boot_image_loader u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .busy(busy), .cpu_hold(cpu_hold)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k);
        logic [31:0] w;
        for (int n = 0; n < 4; n++) w[n*8 +: 8] = 8'((k * 29 + n * 71 + 60) % 256);
        return w;
    endfunction

    // Walk words from `from`; optionally drop request at drop_at
    task automatic check_copy(input int from, input int drop_at);
        for (int k = from; k < 32; k++) begin
            chk("R2 busy", {31'd0, busy}, 32'd1);
            chk("R2 we", {31'd0, ram_we}, 32'd1);
            chk("R2 be", {28'd0, ram_be}, 32'hF);
            chk("R3 addr", {25'd0, ram_addr}, 32'(4 * k));
            chk("R4 data", ram_wdata, exp_word(k));
            chk("R5 hold", {31'd0, cpu_hold}, 32'd1);
            if (k == drop_at) rst_req = 1'b0;
            tick();
        end
        chk("R2 end busy", {31'd0, busy}, 32'd0);
        chk("R2 end we", {31'd0, ram_we}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rst_req = 1'b0;
        tick(); tick();
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk("R1 hold in reset", {31'd0, cpu_hold}, 32'd1);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 we", {31'd0, ram_we}, 32'd0);
        chk("R7 hold before image", {31'd0, cpu_hold}, 32'd1);
    endtask

    task automatic t_basic_copy();
        rst_req = 1'b1;
        tick();
        check_copy(0, -1);
        chk("R5 hold req high", {31'd0, cpu_hold}, 32'd1);
        rst_req = 1'b0;
        #1;
        chk("R6 release idle", {31'd0, cpu_hold}, 32'd0);
        tick();
    endtask

    task automatic t_drop_mid();
        rst_req = 1'b1;
        tick();
        check_copy(0, 10);
        chk("R6 release at end", {31'd0, cpu_hold}, 32'd0);
        tick();
    endtask

    task automatic t_restart_mid();
        rst_req = 1'b1;
        tick();
        for (int k = 0; k < 5; k++) tick();
        chk("R9 at word5", {25'd0, ram_addr}, 32'd20);
        rst_req = 1'b0;
        tick();
        chk("R9 word6", {25'd0, ram_addr}, 32'd24);
        chk("R6 hold after drop", {31'd0, cpu_hold}, 32'd1);
        rst_req = 1'b1;
        tick();
        chk("R9 restart addr", {25'd0, ram_addr}, 32'd0);
        check_copy(0, -1);
    endtask

    task automatic t_held_high();
        for (int i = 0; i < 40; i++) begin
            tick();
            chk("R10 no retrigger", {31'd0, busy}, 32'd0);
        end
        chk("R10 hold", {31'd0, cpu_hold}, 32'd1);
        rst_req = 1'b0;
        tick();
        chk("R8 released", {31'd0, cpu_hold}, 32'd0);
        rst_req = 1'b1;
        tick();
        check_copy(0, 31);
    endtask

    initial begin
        #1;
        t_reset();
        t_basic_copy();
        t_drop_mid();
        t_restart_mid();
        t_held_high();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule